// File: doc/BRIEF.md
# Serial Potentiometer Command Decoder

This block is the serial slave front end of a digitally controlled potentiometer. It works in the system clock domain. It watches an active-low select, a serial clock, a serial data input and an active-low pause input, all of them already synchronised. A transaction runs from a falling edge of select to the next rising edge. The first byte identifies the device, and its lowest bit is compared against a strap input so that two such devices can share one bus. The second byte carries a 4-bit opcode and a 2-bit register pointer. Depending on the opcode, the block then does one of four things:

- issues a transfer request at once;
- collects a third byte and issues a write request;
- fetches a value from the register port and shifts it out MSB first;
- turns every further serial clock pulse into an up or down step strobe.

Register storage, wiper decoding and nonvolatile timing are handled by neighbouring blocks. This block reaches them only through one-cycle strobes and a read request/data pair. Serial data is sampled on rising serial clock and driven on falling serial clock. The serial output is driven only during a read phase, and its enable is low while the output is not driven.

The controller is a single state machine with these states:

- `ST_IDLE`: waiting for select to fall.
- `ST_ID`: collecting the identification byte.
- `ST_INSTR`: collecting the instruction byte.
- `ST_WRITE`: collecting a write data byte.
- `ST_FETCH`: one cycle in which the read data is latched.
- `ST_READ`: shifting the read byte out.
- `ST_STEP`: streaming increment/decrement.
- `ST_SINK`: ignoring the bus until select rises.

Its transitions are:

- Select high sends every state to `ST_IDLE`.
- A select fall enters `ST_ID`.
- In `ST_ID`, a matching byte leads to `ST_INSTR` and any other byte leads to `ST_SINK`.
- `ST_INSTR` goes to `ST_WRITE`, `ST_FETCH`, `ST_STEP` or `ST_SINK`, depending on the opcode.
- `ST_WRITE` goes to `ST_SINK` after its byte.
- `ST_FETCH` goes to `ST_READ` after one cycle.
- `ST_READ` goes to `ST_SINK` after eight clocks.

Top module: `pot_cmd_decoder`

## Requirements
- R1: The first byte after select falls must equal 0101_110 followed by the value of `addr_strap` (MSB first). Any other value makes the block ignore the rest of the transaction until select rises.
- R2: In the instruction byte, bits 7:4 are the opcode and bits 3:2 are the register pointer. The pointer is reported on `cmd_reg` or `rd_reg`.
- R3: Opcode 1101 issues `cmd_stb` with `cmd_kind`=2 (data register to wiper), and opcode 1110 issues it with `cmd_kind`=3 (wiper to data register). Both are issued right after the instruction byte, with no third byte.
- R4: Opcode 1010 (`cmd_kind`=0, write wiper) and opcode 1100 (`cmd_kind`=1, write data register) issue `cmd_stb` after the eighth bit of the third byte. `cmd_data` carries that byte's low six bits, and its top two bits are ignored.
- R5: Opcodes 1001, 1011 and 0101 pulse `rd_req` with `rd_space` = 0 (wiper), 1 (data register) or 2 (status). The block then drives two zero bits followed by the six `rd_data` bits, MSB first, on `ser_out`, changing on each falling serial clock. The MSB is valid after the first falling edge that follows the instruction byte.
- R6: Opcode 0010 turns each later rising serial clock into one `step_stb`, with `step_up` equal to the serial input at that edge. Stepping continues until select rises, past any byte boundary.
- R7: `ser_out_en` is low whenever select is high or no read byte is being shifted. The controller returns to `ST_IDLE` one cycle after select is seen high.
- R8: Pause low, taken while the serial clock is low, freezes the bit position and forces `ser_out_en` low. While paused, serial clock edges have no effect. Pause high, taken while the serial clock is low, resumes the transfer at the same bit.
- R9: After reset, no command is accepted until a falling edge of select has been seen.
- R10: A rising edge of select in the middle of a byte discards the partial command, and no strobe is issued.
- R11: Opcodes other than the eight listed above issue no strobe and no step.
- R12: After reset all strobes and `ser_out_en` are low, and at most one of `cmd_stb`, `rd_req` and `step_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low transaction select |
| ser_clk | input | 1 | Serial clock, synchronised |
| ser_in | input | 1 | Serial data in |
| pause_n | input | 1 | Active-low pause |
| addr_strap | input | 1 | Device address strap compared with ID bit 0 |
| ser_out | output | 1 | Serial data out |
| ser_out_en | output | 1 | High while `ser_out` should be driven |
| rd_req | output | 1 | One-cycle read request |
| rd_space | output | 2 | Read source: 0 wiper, 1 data register, 2 status |
| rd_reg | output | 2 | Data register pointer for the read |
| rd_data | input | 6 | Read value, valid in the cycle after `rd_req` rises |
| cmd_stb | output | 1 | One-cycle write/transfer strobe |
| cmd_kind | output | 2 | 0 write wiper, 1 write register, 2 register to wiper, 3 wiper to register |
| cmd_reg | output | 2 | Data register pointer for the command |
| cmd_data | output | 6 | Write data |
| step_stb | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 up |

## Verification
Every one of the 256 identification byte values is sent with both strap settings, followed by a transfer instruction. This separates the single accepted byte from near misses in the family field, the fixed field and the address bit. Every combination of opcode and pointer is then sent with a third byte whose top bits are set. For each case the bench computes which strobe, kind, pointer, data, step counts and read-back byte must appear, so opcodes, reads, writes and unused codes are told apart. Directed cases cover select low through reset, select rising partway through a byte, pauses in the middle of a write and of a read with clock toggling while paused, and a step stream that runs past a byte boundary.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ID, ST_INSTR, ST_WRITE, ST_FETCH, ST_READ, ST_STEP, ST_SINK
    } dec_state_t;

    typedef enum logic [1:0] {
        CMD_WR_WIPER = 2'd0,
        CMD_WR_DREG  = 2'd1,
        CMD_XFER_D2W = 2'd2,
        CMD_XFER_W2D = 2'd3
    } cmd_kind_t;

    typedef enum logic [1:0] {
        RD_WIPER  = 2'd0,
        RD_DREG   = 2'd1,
        RD_STATUS = 2'd2
    } rd_space_t;

    localparam logic [3:0] ID_FAMILY    = 4'b0101;
    localparam logic [2:0] ID_FIXED     = 3'b110;

    localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
    localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
    localparam logic [3:0] OPC_RD_DREG  = 4'b1011;
    localparam logic [3:0] OPC_WR_DREG  = 4'b1100;
    localparam logic [3:0] OPC_XF_D2W   = 4'b1101;
    localparam logic [3:0] OPC_XF_W2D   = 4'b1110;
    localparam logic [3:0] OPC_STEP     = 4'b0010;
    localparam logic [3:0] OPC_STATUS   = 4'b0101;
endpackage

// File: rtl/pot_link_tracker.sv
module pot_link_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic ser_clk,
    input  logic pause_n,
    output logic sel_fall,
    output logic clk_rise,
    output logic clk_fall,
    output logic held
);
    logic sel_q;
    logic clk_q;

    // sel_q resets low so that select already low at reset is not an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            clk_q <= 1'b0;
            held  <= 1'b0;
        end else begin
            sel_q <= sel_n;
            clk_q <= ser_clk;
            if (sel_n)
                held <= 1'b0;
            else if (!held && !pause_n && !ser_clk)
                held <= 1'b1;
            else if (held && pause_n && !ser_clk)
                held <= 1'b0;
        end
    end

    assign sel_fall = sel_q && !sel_n;
    assign clk_rise = !sel_n && !held && ser_clk && !clk_q;
    assign clk_fall = !sel_n && !held && !ser_clk && clk_q;

    // R8: pause is entered only with the serial clock low
    a_r8_pause_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> !$past(ser_clk));
endmodule

// File: rtl/pot_rx_shifter.sv
module pot_rx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_next,
    output logic         word_done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    assign word_next = {sh[W-2:0], din};
    assign word_done = shift_en && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en) begin
            sh  <= word_next;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pot_tx_shifter.sv
module pot_tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    output logic         so_bit
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            so_bit <= 1'b0;
        end else if (load) begin
            sh <= load_val;
        end else if (shift_en) begin
            so_bit <= sh[W-1];
            sh     <= {sh[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/pot_cmd_decoder.sv
module pot_cmd_decoder
    import pot_cmd_pkg::*;
#(
    parameter int DATA_W    = 6,
    parameter int REG_SEL_W = 2,
    parameter int BYTE_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_n,
    input  logic                 ser_clk,
    input  logic                 ser_in,
    input  logic                 pause_n,
    input  logic                 addr_strap,
    output logic                 ser_out,
    output logic                 ser_out_en,
    output logic                 rd_req,
    output logic [1:0]           rd_space,
    output logic [REG_SEL_W-1:0] rd_reg,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 cmd_stb,
    output logic [1:0]           cmd_kind,
    output logic [REG_SEL_W-1:0] cmd_reg,
    output logic [DATA_W-1:0]    cmd_data,
    output logic                 step_stb,
    output logic                 step_up
);
    localparam int OPC_HI = BYTE_W - 1;
    localparam int OPC_LO = BYTE_W - 4;
    localparam int REG_HI = OPC_LO - 1;
    localparam int REG_LO = OPC_LO - REG_SEL_W;
    localparam int PAD_W  = BYTE_W - DATA_W;

    logic sel_fall, clk_rise, clk_fall, held;
    logic [BYTE_W-1:0] word_next;
    logic word_done;
    logic tx_load, tx_shift;

    dec_state_t state, nxt;
    logic [REG_SEL_W-1:0] op_reg_q, reg_d;
    logic wr_wiper_q, lat_op;
    logic issue_cmd, issue_rd, issue_step;
    cmd_kind_t kind_d;
    rd_space_t space_d;

    pot_link_tracker u_link (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk),
        .pause_n(pause_n), .sel_fall(sel_fall), .clk_rise(clk_rise),
        .clk_fall(clk_fall), .held(held)
    );

    pot_rx_shifter #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(sel_fall), .shift_en(clk_rise),
        .din(ser_in), .word_next(word_next), .word_done(word_done)
    );

    pot_tx_shifter #(.W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load),
        .load_val({{PAD_W{1'b0}}, rd_data}), .shift_en(tx_shift),
        .so_bit(ser_out)
    );

    assign ser_out_en = !sel_n && !held && (state == ST_READ);

    // Next state and decode
    always_comb begin
        nxt        = state;
        lat_op     = 1'b0;
        issue_cmd  = 1'b0;
        issue_rd   = 1'b0;
        issue_step = 1'b0;
        kind_d     = CMD_WR_WIPER;
        space_d    = RD_WIPER;
        reg_d      = op_reg_q;
        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        if (sel_n) begin
            nxt = ST_IDLE;
        end else if (sel_fall) begin
            nxt = ST_ID;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_ID: if (word_done)
                    nxt = (word_next == {ID_FAMILY, ID_FIXED, addr_strap}) ? ST_INSTR : ST_SINK;
                ST_INSTR: if (word_done) begin
                    lat_op = 1'b1;
                    reg_d  = word_next[REG_HI:REG_LO];
                    nxt    = ST_SINK;
                    case (word_next[OPC_HI:OPC_LO])
                        OPC_RD_WIPER: begin issue_rd = 1'b1; space_d = RD_WIPER;  nxt = ST_FETCH; end
                        OPC_RD_DREG:  begin issue_rd = 1'b1; space_d = RD_DREG;   nxt = ST_FETCH; end
                        OPC_STATUS:   begin issue_rd = 1'b1; space_d = RD_STATUS; nxt = ST_FETCH; end
                        OPC_WR_WIPER, OPC_WR_DREG: nxt = ST_WRITE;
                        OPC_XF_D2W:   begin issue_cmd = 1'b1; kind_d = CMD_XFER_D2W; end
                        OPC_XF_W2D:   begin issue_cmd = 1'b1; kind_d = CMD_XFER_W2D; end
                        OPC_STEP:     nxt = ST_STEP;
                        default:      nxt = ST_SINK;
                    endcase
                end
                ST_WRITE: if (word_done) begin
                    issue_cmd = 1'b1;
                    kind_d    = wr_wiper_q ? CMD_WR_WIPER : CMD_WR_DREG;
                    nxt       = ST_SINK;
                end
                ST_FETCH: begin
                    tx_load = 1'b1;
                    nxt     = ST_READ;
                end
                ST_READ: begin
                    tx_shift = clk_fall;
                    if (word_done) nxt = ST_SINK;
                end
                ST_STEP: issue_step = clk_rise;
                ST_SINK: nxt = ST_SINK;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            op_reg_q   <= '0;
            wr_wiper_q <= 1'b0;
        end else begin
            state <= nxt;
            if (lat_op) begin
                op_reg_q   <= reg_d;
                wr_wiper_q <= (word_next[OPC_HI:OPC_LO] == OPC_WR_WIPER);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb  <= 1'b0;
            cmd_kind <= '0;
            cmd_reg  <= '0;
            cmd_data <= '0;
            rd_req   <= 1'b0;
            rd_space <= '0;
            rd_reg   <= '0;
            step_stb <= 1'b0;
            step_up  <= 1'b0;
        end else begin
            cmd_stb  <= issue_cmd;
            rd_req   <= issue_rd;
            step_stb <= issue_step;
            if (issue_cmd) begin
                cmd_kind <= kind_d;
                cmd_reg  <= reg_d;
                cmd_data <= word_next[DATA_W-1:0];
            end
            if (issue_rd) begin
                rd_space <= space_d;
                rd_reg   <= reg_d;
            end
            if (issue_step) step_up <= ser_in;
        end
    end

    // R7: deselect returns the controller to idle
    a_r7_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (state == ST_IDLE));
    // R9: idle is left only on a select fall
    a_r9_wait_for_select_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sel_fall) |=> (state == ST_IDLE));
    // R10: no strobe follows a select rise
    a_r10_no_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |=> !(cmd_stb || rd_req || step_stb));
    // R6: steps come only from the stepping state
    a_r6_step_from_step_state: assert property (@(posedge clk) disable iff (!rst_n)
        step_stb |-> ($past(state) == ST_STEP));
    // R4: commands come only from instruction or write decode
    a_r4_cmd_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> ($past(state) == ST_INSTR || $past(state) == ST_WRITE));
    // R8: nothing is issued from a paused cycle
    a_r8_no_strobe_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(held) |-> !(cmd_stb || rd_req || step_stb));
    // R12: strobes are mutually exclusive
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, rd_req, step_stb}));
endmodule

// File: tb/pot_cmd_decoder_bench.sv
module pot_cmd_decoder_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_in = 1'b0;
    logic pause_n = 1'b1;
    logic addr_strap = 1'b0;
    logic ser_out, ser_out_en, rd_req, cmd_stb, step_stb, step_up;
    logic [1:0] rd_space, rd_reg, cmd_kind, cmd_reg;
    logic [5:0] rd_data, cmd_data;

    always #4 clk = ~clk;

    pot_cmd_decoder u_pot_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(ser_in),
        .pause_n(pause_n), .addr_strap(addr_strap), .ser_out(ser_out),
        .ser_out_en(ser_out_en), .rd_req(rd_req), .rd_space(rd_space), .rd_reg(rd_reg),
        .rd_data(rd_data), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_reg(cmd_reg),
        .cmd_data(cmd_data), .step_stb(step_stb), .step_up(step_up)
    );

    localparam logic [5:0] WIPER_VAL  = 6'h2B;
    localparam logic [5:0] STATUS_VAL = 6'h01;

    function automatic logic [5:0] dreg_val(input logic [1:0] r);
        return 6'(int'(r) * 23 + 9);
    endfunction

    always_comb begin
        case (rd_space)
            2'd0:    rd_data = WIPER_VAL;
            2'd1:    rd_data = dreg_val(rd_reg);
            default: rd_data = STATUS_VAL;
        endcase
    end

    int checks = 0, errors = 0;
    int n_cmd = 0, n_rd = 0, n_up = 0, n_dn = 0;
    logic [1:0] l_kind, l_reg, l_space, l_rdreg;
    logic [5:0] l_data;
    logic [7:0] got;
    logic oe_all, oe_any;

    always @(negedge clk) if (rst_n) begin
        if (cmd_stb) begin n_cmd++; l_kind = cmd_kind; l_reg = cmd_reg; l_data = cmd_data; end
        if (rd_req) begin n_rd++; l_space = rd_space; l_rdreg = rd_reg; end
        if (step_stb) begin if (step_up) n_up++; else n_dn++; end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        ser_clk = 1'b0; ser_in = b;
        waitn(4);
        got = {got[6:0], ser_out};
        oe_all = oe_all & ser_out_en;
        oe_any = oe_any | ser_out_en;
        ser_clk = 1'b1;
        waitn(4);
    endtask

    task automatic sbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic open_rx();
        got = '0; oe_all = 1'b1; oe_any = 1'b0;
    endtask

    task automatic sel_start();
        sel_n = 1'b1; ser_clk = 1'b0; waitn(2);
        sel_n = 1'b0; waitn(3);
    endtask

    task automatic sel_end();
        ser_clk = 1'b0; waitn(4);
        sel_n = 1'b1; waitn(6);
    endtask

    task automatic pause_toggle();
        ser_clk = 1'b0; waitn(4);
        pause_n = 1'b0; waitn(4);
        for (int k = 0; k < 3; k++) begin
            ser_in = 1'b1; ser_clk = 1'b1; waitn(4);
            chk("R8 oe low while paused", int'(ser_out_en), 0);
            ser_clk = 1'b0; waitn(4);
        end
        pause_n = 1'b1; waitn(4);
    endtask

    function automatic logic [7:0] id_byte(input logic a);
        return {4'b0101, 3'b110, a};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int c0, r0, u0, d0;
        // R9: select held low through reset
        sel_n = 1'b0;
        waitn(5);
        rst_n = 1'b1;
        waitn(2);
        chk("R12 reset cmd_stb", int'(cmd_stb), 0);
        chk("R12 reset rd_req", int'(rd_req), 0);
        chk("R12 reset step_stb", int'(step_stb), 0);
        chk("R12 reset ser_out_en", int'(ser_out_en), 0);
        sbyte(id_byte(1'b0));
        sbyte(8'hD8);
        ser_clk = 1'b0; waitn(4);
        chk("R9 no command before select fall", n_cmd, 0);
        sel_n = 1'b1; waitn(6);

        // R1: every ID byte, both straps
        for (int a = 0; a < 2; a++) begin
            for (int v = 0; v < 256; v++) begin
                logic acc;
                addr_strap = 1'(a);
                c0 = n_cmd;
                sel_start();
                sbyte(8'(v));
                sbyte(8'hD8);
                sel_end();
                acc = (8'(v) == id_byte(1'(a)));
                chk("R1 id match", n_cmd - c0, acc ? 1 : 0);
                if (acc) begin
                    chk("R3 transfer kind", int'(l_kind), 2);
                    chk("R2 transfer pointer", int'(l_reg), 2);
                end
            end
        end
        addr_strap = 1'b1;

        // Opcode and pointer sweep
        for (int o = 0; o < 16; o++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] d;
                logic [3:0] ob;
                logic [1:0] rb;
                int exp_cmd, exp_rd, ups;
                ob = 4'(o); rb = 2'(r);
                d = 8'hC0 | 8'(((o * 4 + r) * 5) & 63);
                c0 = n_cmd; r0 = n_rd; u0 = n_up; d0 = n_dn;
                sel_start();
                sbyte(id_byte(1'b1));
                sbyte({ob, rb, 2'b00});
                open_rx();
                sbyte(d);
                sel_end();
                chk("R7 oe low after deselect", int'(ser_out_en), 0);
                exp_cmd = (ob inside {4'b1010, 4'b1100, 4'b1101, 4'b1110}) ? 1 : 0;
                exp_rd  = (ob inside {4'b1001, 4'b1011, 4'b0101}) ? 1 : 0;
                ups = (ob == 4'b0010) ? $countones(d) : 0;
                chk("R11 command count", n_cmd - c0, exp_cmd);
                chk("R11 read count", n_rd - r0, exp_rd);
                chk("R6 up steps", n_up - u0, ups);
                chk("R6 down steps", n_dn - d0, (ob == 4'b0010) ? 8 - ups : 0);
                if (exp_rd == 0)
                    chk("R7 oe low outside read", int'(oe_any), 0);
                case (ob)
                    4'b1010: begin
                        chk("R4 write wiper kind", int'(l_kind), 0);
                        chk("R4 write wiper data", int'(l_data), int'(d[5:0]));
                    end
                    4'b1100: begin
                        chk("R4 write reg kind", int'(l_kind), 1);
                        chk("R2 write reg pointer", int'(l_reg), r);
                        chk("R4 write reg data", int'(l_data), int'(d[5:0]));
                    end
                    4'b1101: begin
                        chk("R3 d2w kind", int'(l_kind), 2);
                        chk("R2 d2w pointer", int'(l_reg), r);
                    end
                    4'b1110: begin
                        chk("R3 w2d kind", int'(l_kind), 3);
                        chk("R2 w2d pointer", int'(l_reg), r);
                    end
                    4'b1001: begin
                        chk("R5 wiper space", int'(l_space), 0);
                        chk("R5 wiper byte", int'(got), int'({2'b00, WIPER_VAL}));
                        chk("R5 oe during read", int'(oe_all), 1);
                    end
                    4'b1011: begin
                        chk("R5 reg space", int'(l_space), 1);
                        chk("R2 read pointer", int'(l_rdreg), r);
                        chk("R5 reg byte", int'(got), int'({2'b00, dreg_val(rb)}));
                        chk("R5 oe during read", int'(oe_all), 1);
                    end
                    4'b0101: begin
                        chk("R5 status space", int'(l_space), 2);
                        chk("R5 status byte", int'(got), int'({2'b00, STATUS_VAL}));
                    end
                    default: ;
                endcase
            end
        end

        // R6: stepping runs past a byte boundary
        u0 = n_up; d0 = n_dn;
        sel_start();
        sbyte(id_byte(1'b1));
        sbyte(8'h20);
        for (int k = 0; k < 13; k++) sbit(1'((k % 3) == 0));
        sel_end();
        chk("R6 long stream up", n_up - u0, 5);
        chk("R6 long stream down", n_dn - d0, 8);

        // R10: select rises partway through a write data byte
        c0 = n_cmd;
        sel_start();
        sbyte(id_byte(1'b1));
        sbyte(8'hA0);
        for (int k = 0; k < 4; k++) sbit(1'b1);
        sel_end();
        chk("R10 partial write dropped", n_cmd - c0, 0);
        // R10: select rises partway through the instruction byte
        sel_start();
        sbyte(id_byte(1'b1));
        for (int k = 0; k < 6; k++) sbit(k[0]);
        sel_end();
        chk("R10 partial instruction dropped", n_cmd - c0, 0);

        // R8: pause in the middle of a write
        c0 = n_cmd;
        sel_start();
        sbyte(id_byte(1'b1));
        sbyte(8'hA0);
        for (int i = 7; i >= 5; i--) sbit(1'(8'h2A >> i));
        pause_toggle();
        for (int i = 4; i >= 0; i--) sbit(1'(8'h2A >> i));
        sel_end();
        chk("R8 write after pause count", n_cmd - c0, 1);
        chk("R8 write after pause data", int'(l_data), 6'h2A);

        // R8: pause in the middle of a read
        sel_start();
        sbyte(id_byte(1'b1));
        sbyte(8'hB4);
        open_rx();
        sbit(1'b0); sbit(1'b0);
        pause_toggle();
        for (int k = 0; k < 6; k++) sbit(1'b0);
        sel_end();
        chk("R8 read after pause byte", int'(got), int'({2'b00, dreg_val(2'd1)}));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule